// File: doc/BRIEF.md
# Block-Mapped Flash Address Translator

This block turns a logical page number into a physical flash location given as a block and a page. The logical number is split into a virtual block index and an offset within that block. Each virtual block owns a table entry holding a home block and, once it is needed, an overflow block. A first write to an offset lands on that same offset in the home block. A rewrite of an offset that is already used cannot go back to the home page. Instead it is appended to the overflow block. Overflow pages are filled strictly from page 0 upward.

Each overflow page keeps an on-chip tag holding the logical offset it carries. Stale copies are never marked dead, so a read scans these tags and picks the newest match. If no tag matches, the read falls back to the home page when that page has been used. Otherwise the read reports the location as unmapped.

When a write needs a block that has not been assigned yet, the block raises a request and stalls. It stays stalled until an external allocator grants a free physical block number. When the overflow block of a virtual block is full, a write is refused with a full status, so that a merge step outside this block can run. The block keeps its mapping and used-page state in small on-chip tables. It does not drive the flash itself.

Top module: `blkmap_xlat`

## Requirements
- R1: A logical page number L maps to virtual block L / PPB and offset L % PPB (PPB is a power of two, so the offset is the low log2(PPB) bits). With PPB = 8, L = 27 gives virtual block 3 and offset 3.
- R2: A write to a virtual block with no home block sets blkReq to 1 from the cycle after acceptance and drops reqReady to 0, and both stay that way until a cycle in which blkGrant is 1. The granted number becomes the home block, and the write is answered at the home block at page = offset.
- R3: A write whose home block exists and whose home page at that offset is unused is answered with (home block, offset). That page is then marked used.
- R4: A write whose home page is already used is answered in the overflow block at page index n, where n counts the writes already placed in that overflow block (0, 1, 2, ... ascending, none skipped or repeated).
- R5: If R4 applies and no overflow block exists yet, the block stalls and requests a block as in R2. The granted number becomes the overflow block, and the write is answered at page 0 of it.
- R6: If R4 applies and all PPB overflow pages are already written, the write is answered with rspFull = 1, rspUnmapped = 0 and rspBlk = rspPage = 0, and no mapping changes. A later read returns the same result as before that write.
- R7: A read returns the overflow block and the highest-indexed written overflow page whose tag equals the requested offset, when such a page exists.
- R8: A read with no matching overflow tag returns (home block, offset) if that home page is used.
- R9: A read whose home page is unused, or whose virtual block has no home block, and which has no matching tag, answers with rspUnmapped = 1, rspFull = 0 and rspBlk = rspPage = 0.
- R10: Every accepted request gets exactly one rspValid pulse of one cycle. The pulse comes in the cycle after the accepting clock edge, or in the cycle after the granting edge when the request stalled. reqReady is 1 whenever no request is stalled.
- R11: After reset, reqReady = 1, blkReq = 0 and rspValid = 0, and every virtual block has no home block, no overflow block and no used pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLpa | input | LPA_W (6) | Logical page number |
| reqReady | output | 1 | Request accepted on this edge when reqValid is 1 |
| blkReq | output | 1 | Asking for a free physical block |
| blkGrant | input | 1 | Grant of a free block |
| blkGrantNum | input | PB_W (5) | Granted physical block number |
| rspValid | output | 1 | Response pulse |
| rspUnmapped | output | 1 | Read found no copy |
| rspFull | output | 1 | Write refused, overflow block full |
| rspBlk | output | PB_W (5) | Physical block of the response |
| rspPage | output | OFF_W (3) | Physical page of the response |

## Verification
The hardest state to reach from the ports is an overflow block that holds several stale copies of one offset mixed with copies of other offsets, and that then fills completely. Only in that state do the newest-match rule of the read scan and the full refusal both matter. A directed run builds this on one virtual block by alternating rewrites of two offsets until the block is full, then reads both offsets back. A long random run concentrated on few logical pages then drives many virtual blocks through overflow, stalls of varying grant delay, and the full state. Every answer is compared with a bench model of the tables.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the incoming request, a stall follows
    logic fire;      // execute the operation this cycle
    logic useHeld;   // operate on the latched request
    logic grantNow;  // a granted block number is present this cycle
  } xlatStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_STALL = 1'b1
  } xlatState_t;
endpackage

// File: rtl/blkmap_ctrl.sv
module blkmap_ctrl
  import blkmap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        needBlk,
  input  logic        blkGrant,
  output logic        reqReady,
  output logic        blkReq,
  output xlatStrobe_t strobe
);
  xlatState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (needBlk) begin
            strobe.capture = 1'b1;
            stateNext      = ST_STALL;
          end else begin
            strobe.fire = 1'b1;
          end
        end
      end
      ST_STALL: begin
        strobe.useHeld = 1'b1;
        if (blkGrant) begin
          strobe.fire     = 1'b1;
          strobe.grantNow = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign blkReq   = (state == ST_STALL);

  // R2
  blk_req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkReq && !blkGrant |=> blkReq);
  // R2
  grant_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkReq && blkGrant |=> !blkReq && reqReady);
  // R5
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkReq |-> !reqReady);
endmodule

// File: rtl/blkmap_dpath.sv
module blkmap_dpath
  import blkmap_pkg::*;
#(
  parameter int NV    = 8,
  parameter int PPB   = 8,
  parameter int NPB   = 32,
  localparam int OFF_W  = $clog2(PPB),
  localparam int VBA_W  = (NV > 1) ? $clog2(NV) : 1,
  localparam int LPA_W  = OFF_W + VBA_W,
  localparam int PB_W   = $clog2(NPB),
  localparam int FILL_W = $clog2(PPB + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  xlatStrobe_t      strobe,
  input  logic             reqWrite,
  input  logic [LPA_W-1:0] reqLpa,
  input  logic [PB_W-1:0]  blkGrantNum,
  output logic             needBlk,
  output logic             rspValid,
  output logic             rspUnmapped,
  output logic             rspFull,
  output logic [PB_W-1:0]  rspBlk,
  output logic [OFF_W-1:0] rspPage
);
  // mapping tables
  logic [PB_W-1:0]   homeBlk  [NV];
  logic              homeVal  [NV];
  logic [PB_W-1:0]   ovfBlk   [NV];
  logic              ovfVal   [NV];
  logic [FILL_W-1:0] fillCnt  [NV];
  logic [PPB-1:0]    pageUsed [NV];
  logic [OFF_W-1:0]  tagMem   [NV][PPB];

  // latched request for stalls
  logic             heldWrite;
  logic [LPA_W-1:0] heldLpa;

  logic             opWrite;
  logic [LPA_W-1:0] opLpa;
  logic [VBA_W-1:0] vba;
  logic [OFF_W-1:0] off;

  assign opWrite = strobe.useHeld ? heldWrite : reqWrite;
  assign opLpa   = strobe.useHeld ? heldLpa   : reqLpa;
  assign vba     = opLpa[LPA_W-1:OFF_W];
  assign off     = opLpa[OFF_W-1:0];

  logic              curHomeVal, curOvfVal, curUsed;
  logic [PB_W-1:0]   curHome, curOvf;
  logic [FILL_W-1:0] curFill;

  assign curHomeVal = homeVal[vba];
  assign curHome    = homeBlk[vba];
  assign curOvfVal  = ovfVal[vba];
  assign curOvf     = ovfBlk[vba];
  assign curFill    = fillCnt[vba];
  assign curUsed    = pageUsed[vba][off];

  // write classification
  logic wrHome, wrOvf, wrFull;
  assign wrHome = opWrite && (!curHomeVal || !curUsed);
  assign wrOvf  = opWrite && curHomeVal && curUsed &&
                  (!curOvfVal || (curFill < FILL_W'(PPB)));
  assign wrFull = opWrite && curHomeVal && curUsed && curOvfVal &&
                  (curFill == FILL_W'(PPB));
  assign needBlk = opWrite && (!curHomeVal || (curUsed && !curOvfVal));

  logic [PB_W-1:0]  tgtHome, tgtOvf;
  logic [OFF_W-1:0] tgtOvfPage;
  assign tgtHome    = curHomeVal ? curHome : blkGrantNum;
  assign tgtOvf     = curOvfVal  ? curOvf  : blkGrantNum;
  assign tgtOvfPage = curOvfVal  ? curFill[OFF_W-1:0] : '0;

  // newest-first tag scan over the written overflow pages
  logic             hit;
  logic [OFF_W-1:0] hitIdx;
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < PPB; i++) begin
      if (curOvfVal && (FILL_W'(i) < curFill) && (tagMem[vba][i] == off)) begin
        hit    = 1'b1;
        hitIdx = OFF_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldWrite <= 1'b0;
      heldLpa   <= '0;
    end else if (strobe.capture) begin
      heldWrite <= reqWrite;
      heldLpa   <= reqLpa;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspUnmapped <= 1'b0;
      rspFull     <= 1'b0;
      rspBlk      <= '0;
      rspPage     <= '0;
      for (int v = 0; v < NV; v++) begin
        homeBlk[v]  <= '0;
        homeVal[v]  <= 1'b0;
        ovfBlk[v]   <= '0;
        ovfVal[v]   <= 1'b0;
        fillCnt[v]  <= '0;
        pageUsed[v] <= '0;
        for (int p = 0; p < PPB; p++) tagMem[v][p] <= '0;
      end
    end else begin
      rspValid <= strobe.fire;
      if (strobe.fire) begin
        rspUnmapped <= 1'b0;
        rspFull     <= 1'b0;
        rspBlk      <= '0;
        rspPage     <= '0;
        if (opWrite) begin
          if (wrHome) begin
            homeBlk[vba]       <= tgtHome;
            homeVal[vba]       <= 1'b1;
            pageUsed[vba][off] <= 1'b1;
            rspBlk             <= tgtHome;
            rspPage            <= off;
          end else if (wrOvf) begin
            ovfBlk[vba]             <= tgtOvf;
            ovfVal[vba]             <= 1'b1;
            tagMem[vba][tgtOvfPage] <= off;
            fillCnt[vba]            <= (curOvfVal ? curFill : '0) + 1'b1;
            rspBlk                  <= tgtOvf;
            rspPage                 <= tgtOvfPage;
          end else if (wrFull) begin
            rspFull <= 1'b1;
          end
        end else begin
          if (hit) begin
            rspBlk  <= curOvf;
            rspPage <= hitIdx;
          end else if (curHomeVal && curUsed) begin
            rspBlk  <= curHome;
            rspPage <= off;
          end else begin
            rspUnmapped <= 1'b1;
          end
        end
      end
    end
  end

  // R10
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(strobe.fire));
  // R9
  status_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspUnmapped, rspFull}));
  // R5
  first_ovf_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire && strobe.grantNow && curHomeVal |=> rspPage == '0);

  generate
    for (genvar gv = 0; gv < NV; gv++) begin : g_fillChk
      // R4
      fill_step_chk: assert property (@(posedge clk) disable iff (!rstN)
        (fillCnt[gv] == $past(fillCnt[gv])) ||
        (fillCnt[gv] == $past(fillCnt[gv]) + 1'b1));
      // R6
      fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
        fillCnt[gv] <= FILL_W'(PPB));
    end
  endgenerate
endmodule

// File: rtl/blkmap_xlat.sv
module blkmap_xlat
  import blkmap_pkg::*;
#(
  parameter int NV    = 8,
  parameter int PPB   = 8,
  parameter int NPB   = 32,
  localparam int OFF_W = $clog2(PPB),
  localparam int VBA_W = (NV > 1) ? $clog2(NV) : 1,
  localparam int LPA_W = OFF_W + VBA_W,
  localparam int PB_W  = $clog2(NPB)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LPA_W-1:0] reqLpa,
  output logic             reqReady,
  output logic             blkReq,
  input  logic             blkGrant,
  input  logic [PB_W-1:0]  blkGrantNum,
  output logic             rspValid,
  output logic             rspUnmapped,
  output logic             rspFull,
  output logic [PB_W-1:0]  rspBlk,
  output logic [OFF_W-1:0] rspPage
);
  xlatStrobe_t strobe;
  logic        needBlk;

  blkmap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .needBlk  (needBlk),
    .blkGrant (blkGrant),
    .reqReady (reqReady),
    .blkReq   (blkReq),
    .strobe   (strobe)
  );

  blkmap_dpath #(.NV(NV), .PPB(PPB), .NPB(NPB)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqWrite    (reqWrite),
    .reqLpa      (reqLpa),
    .blkGrantNum (blkGrantNum),
    .needBlk     (needBlk),
    .rspValid    (rspValid),
    .rspUnmapped (rspUnmapped),
    .rspFull     (rspFull),
    .rspBlk      (rspBlk),
    .rspPage     (rspPage)
  );
endmodule

// File: tb/blkmap_xlat_test.sv
module blkmap_xlat_test;
  localparam int NV = 8, PPB = 8, NPB = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqWrite = 1'b0;
  logic [5:0] reqLpa = '0;
  logic       reqReady, blkReq;
  logic       blkGrant = 1'b0;
  logic [4:0] blkGrantNum = '0;
  logic       rspValid, rspUnmapped, rspFull;
  logic [4:0] rspBlk;
  logic [2:0] rspPage;

  always #4 clk = ~clk; // 125 MHz

  blkmap_xlat #(.NV(NV), .PPB(PPB), .NPB(NPB)) uut (.*);

  int checks = 0, errs = 0;
  bit done = 1'b0;
  int gNext = 3;

  // bench model of the tables
  bit mHomeVal [NV];
  int mHome    [NV];
  bit mOvfVal  [NV];
  int mOvf     [NV];
  int mFill    [NV];
  bit mUsed    [NV][PPB];
  int mTag     [NV][PPB];

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected read answer: blk, page, unmapped
  function automatic void expRead(input int lpa, output int eb, output int ep,
                                  output int eu, output string tag);
    int v = lpa / PPB;
    int o = lpa % PPB;
    int hitI = -1;
    if (mOvfVal[v])
      for (int i = 0; i < mFill[v]; i++) if (mTag[v][i] == o) hitI = i;
    if (hitI >= 0) begin
      eb = mOvf[v]; ep = hitI; eu = 0; tag = "R7";
    end else if (mHomeVal[v] && mUsed[v][o]) begin
      eb = mHome[v]; ep = o; eu = 0; tag = "R8";
    end else begin
      eb = 0; ep = 0; eu = 1; tag = "R9";
    end
  endfunction

  task automatic doOp(input bit wr, input int lpa, input int delay);
    int v = lpa / PPB;
    int o = lpa % PPB;
    int eb = 0, ep = 0, eu = 0, ef = 0;
    bit needB = 1'b0;
    string tag;
    @(negedge clk);
    chk("R10", rspValid, 0, "pulse ended");
    chk("R10", reqReady, 1, "ready idle");
    if (wr) begin
      if (!mHomeVal[v]) begin
        needB = 1'b1; tag = "R2";
      end else if (!mUsed[v][o]) tag = "R3";
      else if (!mOvfVal[v]) begin
        needB = 1'b1; tag = "R5";
      end else if (mFill[v] < PPB) tag = "R4";
      else tag = "R6";
    end
    reqValid = 1'b1; reqWrite = wr; reqLpa = 6'(lpa);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (needB) begin
      chk(tag, blkReq, 1, "block request");
      chk(tag, reqReady, 0, "stalled");
      chk("R10", rspValid, 0, "no early answer");
      for (int d = 0; d < delay; d++) begin
        @(negedge clk);
        chk(tag, blkReq, 1, "request held");
      end
      blkGrant = 1'b1; blkGrantNum = 5'(gNext);
      @(posedge clk);
      @(negedge clk);
      blkGrant = 1'b0;
    end else begin
      chk("R2", blkReq, 0, "no request");
    end
    if (wr) begin
      if (tag == "R2") begin
        mHomeVal[v] = 1; mHome[v] = gNext; gNext = (gNext + 7) % NPB;
      end else if (tag == "R5") begin
        mOvfVal[v] = 1; mOvf[v] = gNext; mFill[v] = 0; gNext = (gNext + 7) % NPB;
      end
      if (tag == "R2" || tag == "R3") begin
        eb = mHome[v]; ep = o; mUsed[v][o] = 1;
      end else if (tag == "R4" || tag == "R5") begin
        eb = mOvf[v]; ep = mFill[v]; mTag[v][mFill[v]] = o; mFill[v]++;
      end else ef = 1;
    end else expRead(lpa, eb, ep, eu, tag);
    chk("R10", rspValid, 1, "answer pulse");
    chk(tag, rspBlk, eb, "block");
    chk(tag == "R2" || tag == "R3" ? "R1" : tag, rspPage, ep, "page");
    chk(tag, rspUnmapped, eu, "unmapped");
    chk(tag, rspFull, ef, "full");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", reqReady, 1, "ready after reset");
    chk("R11", blkReq, 0, "no request after reset");
    chk("R11", rspValid, 0, "no answer after reset");
    rstN = 1'b1;

    // directed: virtual block 3, offsets 3 and 2 (lpa 27, 26)
    doOp(0, 27, 0);  // R9 nothing mapped
    doOp(1, 27, 2);  // R2 home block granted, R1 page 3
    doOp(0, 27, 0);  // R8
    doOp(1, 27, 0);  // R5 overflow granted at page 0
    doOp(1, 26, 0);  // R3 home page 2
    doOp(1, 27, 0);  // R4 overflow page 1
    doOp(1, 26, 0);  // R4 overflow page 2
    doOp(0, 27, 0);  // R7 newest copy page 1
    doOp(0, 26, 0);  // R7 page 2
    doOp(0, 25, 0);  // R9 home page unused
    for (int k = 0; k < 5; k++) doOp(1, (k % 2) ? 26 : 27, 0); // fill to 8
    doOp(1, 27, 0);  // R6 full refusal
    doOp(1, 25, 0);  // R3 home still free
    doOp(0, 27, 0);  // R6/R7 unchanged after refusal
    doOp(0, 26, 0);

    // random traffic, fixed seed
    void'($urandom(32'h5eed));
    for (int n = 0; n < 500; n++) begin
      int lpa = (($urandom % 4) == 0) ? ($urandom % 64) : ($urandom % 16);
      doOp(bit'($urandom % 3 != 0), lpa, $urandom % 4);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule